// File: doc/BRIEF.md
# Sixteen-Bit Grouped-Opcode Arithmetic Logic Unit

This block is a purely combinational datapath unit. It takes two 16-bit operands and a five-bit operation code, and it returns a 16-bit result together with one overflow flag. The operation code has two fields. The upper two bits choose a family of operations: arithmetic, bitwise logic, shifting, or signed comparison. The lower three bits choose one operation inside that family. Any sub-code that a family does not define yields an all-zero result with the flag low.

The unit holds no state and has no clock. It sits between operand-fetch and write-back logic that are registered somewhere else. The result and the flag settle within the same cycle as the operands and the code. The block is combinational, so it has no stream handshake and no back-pressure. Whatever the surrounding pipeline stage presents, it sees the answer after one propagation delay.

Top module: `alu16_core`

## Requirements
- R1: Bits [4:3] of `op_code` select the family: 00 arithmetic, 01 logic, 10 shift, 11 compare. Bits [2:0] select the operation within that family.
- R2: The arithmetic sub-codes, taken modulo 2^16, are: 000 signed A+B, 001 unsigned A+B, 010 signed A−B, 011 unsigned A−B, 100 A+1, 101 A−1.
- R3: For arithmetic sub-codes 000, 010, 100 and 101, `ovf_flag` is high exactly when the two's-complement result lies outside −32768..32767. For 001 it equals the carry out of bit 15. For 011 it is high exactly when A < B, taken as unsigned numbers.
- R4: The logic sub-codes are 000 A AND B, 001 A OR B, 010 A XOR B, and 100 NOT A.
- R5: The shift sub-codes are 000 logical left, 001 logical right, 010 arithmetic left and 011 arithmetic right. A is shifted by B[3:0] (0 to 15), and B[15:4] has no effect on the result.
- R6: Arithmetic left shift gives the same bits as logical left shift. Arithmetic right shift fills the vacated high bits with A[15].
- R7: The compare sub-codes treat A and B as signed numbers: 000 A≤B, 001 A<B, 010 A≥B, 011 A>B, 100 A=B, 101 A≠B. The result is 16'h0001 when the condition holds and 16'h0000 when it does not.
- R8: `ovf_flag` is low for every logic, shift and compare code.
- R9: These undefined sub-codes give `result` = 0 and `ovf_flag` = 0: arithmetic 110 and 111; logic 011, 101, 110 and 111; shift 100 through 111; compare 110 and 111.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opnd_a | input | 16 | First operand. It is also the operand that is shifted, incremented, decremented or inverted |
| opnd_b | input | 16 | Second operand. Its low four bits are the shift distance |
| op_code | input | 5 | Family in [4:3], operation in [2:0] |
| result | output | 16 | Operation result |
| ovf_flag | output | 1 | Overflow, carry or borrow indication for the arithmetic family |

## Verification
The sweep crosses every one of the 32 codes with operands chosen at the edges of the number range: 0x7FFF, 0x8000, 0xFFFF, 0 and 1, plus a set of pseudo-random words. The edge operands are there to catch specific mistakes. A design that reads the unsigned carry as the signed flag fails on 0x7FFF+1. A design that forgets the borrow's polarity fails when A equals B. A design that compares unsigned gets 0x8000 < 1 wrong. Shift distances of 0 and 15 are paired with B words whose upper bits are set. This shows up a shifter that uses more than four bits, and an arithmetic right shift that fills with zeros. Every undefined sub-code is applied to non-zero operands, so that a family leaking its default path shows a non-zero result.

// File: rtl/alu16_pkg.sv
package alu16_pkg;
  typedef enum logic [1:0] {
    FAM_ARITH = 2'b00,
    FAM_LOGIC = 2'b01,
    FAM_SHIFT = 2'b10,
    FAM_CMP   = 2'b11
  } fam_e;

  // arithmetic family
  localparam logic [2:0] AR_ADDS = 3'd0;
  localparam logic [2:0] AR_ADDU = 3'd1;
  localparam logic [2:0] AR_SUBS = 3'd2;
  localparam logic [2:0] AR_SUBU = 3'd3;
  localparam logic [2:0] AR_INC  = 3'd4;
  localparam logic [2:0] AR_DEC  = 3'd5;

  // logic family
  localparam logic [2:0] LG_AND = 3'd0;
  localparam logic [2:0] LG_OR  = 3'd1;
  localparam logic [2:0] LG_XOR = 3'd2;
  localparam logic [2:0] LG_INV = 3'd4;

  // shift family
  localparam logic [2:0] SH_LL = 3'd0;
  localparam logic [2:0] SH_LR = 3'd1;
  localparam logic [2:0] SH_AL = 3'd2;
  localparam logic [2:0] SH_AR = 3'd3;

  // compare family
  localparam logic [2:0] CM_LE = 3'd0;
  localparam logic [2:0] CM_LT = 3'd1;
  localparam logic [2:0] CM_GE = 3'd2;
  localparam logic [2:0] CM_GT = 3'd3;
  localparam logic [2:0] CM_EQ = 3'd4;
  localparam logic [2:0] CM_NE = 3'd5;

  // how the arithmetic flag is formed
  typedef enum logic [1:0] {
    FLG_NONE   = 2'd0,
    FLG_SIGNED = 2'd1,
    FLG_CARRY  = 2'd2,
    FLG_BORROW = 2'd3
  } flag_src_e;
endpackage

// File: rtl/alu16_arith.sv
module alu16_arith
  import alu16_pkg::*;
#(
  parameter int WIDTH = 16
) (
  input  logic [WIDTH-1:0] a,
  input  logic [WIDTH-1:0] b,
  input  logic [2:0]       sub,
  output logic [WIDTH-1:0] y,
  output logic             ovf,
  output logic             hit
);
  localparam int MSB = WIDTH - 1;

  logic [WIDTH-1:0] b_eff;
  logic             cin;
  flag_src_e        fsrc;
  logic [WIDTH:0]   sum;
  logic             sgn_ovf;

  // one shared adder; the operation only picks its second input and carry-in
  always_comb begin
    b_eff = '0;
    cin   = 1'b0;
    fsrc  = FLG_NONE;
    hit   = 1'b1;
    unique case (sub)
      AR_ADDS: begin b_eff = b;          fsrc = FLG_SIGNED; end
      AR_ADDU: begin b_eff = b;          fsrc = FLG_CARRY;  end
      AR_SUBS: begin b_eff = ~b; cin = 1'b1; fsrc = FLG_SIGNED; end
      AR_SUBU: begin b_eff = ~b; cin = 1'b1; fsrc = FLG_BORROW; end
      AR_INC:  begin b_eff = '0; cin = 1'b1; fsrc = FLG_SIGNED; end
      AR_DEC:  begin b_eff = '1;         fsrc = FLG_SIGNED; end
      default: hit = 1'b0;
    endcase
  end

  assign sum     = {1'b0, a} + {1'b0, b_eff} + {{WIDTH{1'b0}}, cin};
  assign sgn_ovf = (a[MSB] == b_eff[MSB]) && (sum[MSB] != a[MSB]);

  always_comb begin
    unique case (fsrc)
      FLG_SIGNED: ovf = sgn_ovf;
      FLG_CARRY:  ovf = sum[WIDTH];
      FLG_BORROW: ovf = ~sum[WIDTH];
      default:    ovf = 1'b0;
    endcase
  end

  assign y = sum[MSB:0];
endmodule

// File: rtl/alu16_logic.sv
module alu16_logic
  import alu16_pkg::*;
#(
  parameter int WIDTH = 16
) (
  input  logic [WIDTH-1:0] a,
  input  logic [WIDTH-1:0] b,
  input  logic [2:0]       sub,
  output logic [WIDTH-1:0] y,
  output logic             hit
);
  always_comb begin
    hit = 1'b1;
    unique case (sub)
      LG_AND:  y = a & b;
      LG_OR:   y = a | b;
      LG_XOR:  y = a ^ b;
      LG_INV:  y = ~a;
      default: begin y = '0; hit = 1'b0; end
    endcase
  end
endmodule

// File: rtl/alu16_shift.sv
module alu16_shift
  import alu16_pkg::*;
#(
  parameter int WIDTH = 16,
  parameter int SHW   = $clog2(WIDTH)
) (
  input  logic [WIDTH-1:0] a,
  input  logic [SHW-1:0]   amt,
  input  logic [2:0]       sub,
  output logic [WIDTH-1:0] y,
  output logic             hit
);
  localparam int MSB = WIDTH - 1;

  logic             fill;
  logic [WIDTH-1:0] lstg [0:SHW];
  logic [WIDTH-1:0] rstg [0:SHW];

  assign fill    = (sub == SH_AR) ? a[MSB] : 1'b0;
  assign lstg[0] = a;
  assign rstg[0] = a;

  // logarithmic barrel: stage k moves by 2**k when amt[k] is set
  for (genvar k = 0; k < SHW; k++) begin : g_stage
    localparam int DIST = 1 << k;
    assign lstg[k+1] = amt[k] ? {lstg[k][MSB-DIST:0], {DIST{1'b0}}} : lstg[k];
    assign rstg[k+1] = amt[k] ? {{DIST{fill}}, rstg[k][MSB:DIST]}   : rstg[k];
  end

  always_comb begin
    hit = 1'b1;
    unique case (sub)
      SH_LL, SH_AL: y = lstg[SHW];
      SH_LR, SH_AR: y = rstg[SHW];
      default:      begin y = '0; hit = 1'b0; end
    endcase
  end
endmodule

// File: rtl/alu16_cmp.sv
module alu16_cmp
  import alu16_pkg::*;
#(
  parameter int WIDTH = 16
) (
  input  logic [WIDTH-1:0] a,
  input  logic [WIDTH-1:0] b,
  input  logic [2:0]       sub,
  output logic [WIDTH-1:0] y,
  output logic             hit
);
  logic lt, eq, cond;

  assign lt = $signed(a) < $signed(b);
  assign eq = (a == b);

  always_comb begin
    hit = 1'b1;
    unique case (sub)
      CM_LE:   cond = lt | eq;
      CM_LT:   cond = lt;
      CM_GE:   cond = ~lt;
      CM_GT:   cond = ~(lt | eq);
      CM_EQ:   cond = eq;
      CM_NE:   cond = ~eq;
      default: begin cond = 1'b0; hit = 1'b0; end
    endcase
  end

  assign y = {{(WIDTH-1){1'b0}}, cond};
endmodule

// File: rtl/alu16_core.sv
module alu16_core
  import alu16_pkg::*;
#(
  parameter int WIDTH = 16
) (
  input  logic [WIDTH-1:0] opnd_a,
  input  logic [WIDTH-1:0] opnd_b,
  input  logic [4:0]       op_code,
  output logic [WIDTH-1:0] result,
  output logic             ovf_flag
);
  localparam int SHW = $clog2(WIDTH);

  fam_e       fam;
  logic [2:0] sub;

  logic [WIDTH-1:0] ar_y, lg_y, sh_y, cm_y;
  logic             ar_ovf, ar_hit, lg_hit, sh_hit, cm_hit;

  assign fam = fam_e'(op_code[4:3]);
  assign sub = op_code[2:0];

  alu16_arith #(.WIDTH(WIDTH)) u_arith (
    .a(opnd_a), .b(opnd_b), .sub(sub), .y(ar_y), .ovf(ar_ovf), .hit(ar_hit)
  );
  alu16_logic #(.WIDTH(WIDTH)) u_logic (
    .a(opnd_a), .b(opnd_b), .sub(sub), .y(lg_y), .hit(lg_hit)
  );
  alu16_shift #(.WIDTH(WIDTH), .SHW(SHW)) u_shift (
    .a(opnd_a), .amt(opnd_b[SHW-1:0]), .sub(sub), .y(sh_y), .hit(sh_hit)
  );
  alu16_cmp #(.WIDTH(WIDTH)) u_cmp (
    .a(opnd_a), .b(opnd_b), .sub(sub), .y(cm_y), .hit(cm_hit)
  );

  // family select; a unit that does not recognise its sub-code yields zero
  always_comb begin
    result   = '0;
    ovf_flag = 1'b0;
    unique case (fam)
      FAM_ARITH: if (ar_hit) begin result = ar_y; ovf_flag = ar_ovf; end
      FAM_LOGIC: if (lg_hit) result = lg_y;
      FAM_SHIFT: if (sh_hit) result = sh_y;
      default:   if (cm_hit) result = cm_y;
    endcase
  end
endmodule

// File: rtl/alu16_core_chk.sv
module alu16_core_chk #(
  parameter int WIDTH = 16
) (
  input logic [WIDTH-1:0] opnd_a,
  input logic [WIDTH-1:0] opnd_b,
  input logic [4:0]       op_code,
  input logic [WIDTH-1:0] result,
  input logic             ovf_flag
);
  localparam int SHW = $clog2(WIDTH);

  logic undef_code;
  always_comb begin
    unique case (op_code[4:3])
      2'b00:   undef_code = op_code[2:0] > 3'd5;
      2'b01:   undef_code = (op_code[2:0] == 3'd3) || (op_code[2:0] > 3'd4);
      2'b10:   undef_code = op_code[2];
      default: undef_code = op_code[2:0] > 3'd5;
    endcase
  end

  always_comb begin
    if (op_code[4:3] != 2'b00)
      AST_NO_OVERFLOW: assert (!ovf_flag); // R8
    if (op_code[4:3] == 2'b11)
      AST_CMP_BOOL: assert (result[WIDTH-1:1] == '0); // R7
    if (op_code == 5'b11100 && opnd_a == opnd_b)
      AST_CMP_EQ_SET: assert (result == {{(WIDTH-1){1'b0}}, 1'b1}); // R7
    if (undef_code)
      AST_UNDEF_ZERO: assert (result == '0 && !ovf_flag); // R9
    if (op_code[4:3] == 2'b10 && !op_code[2] && opnd_b[SHW-1:0] == '0)
      AST_SHIFT_NONE: assert (result == opnd_a); // R5
    if (op_code == 5'b01100)
      AST_INVERT: assert ((result ^ opnd_a) == '1); // R4
    if (op_code == 5'b00011 && opnd_a == opnd_b)
      AST_SUBU_EQUAL: assert (result == '0 && !ovf_flag); // R3
  end
endmodule

bind alu16_core alu16_core_chk #(.WIDTH(WIDTH)) u_chk (
  .opnd_a(opnd_a), .opnd_b(opnd_b), .op_code(op_code),
  .result(result), .ovf_flag(ovf_flag)
);

// File: tb/alu16_core_test.sv
module alu16_core_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic [15:0] opnd_a = '0, opnd_b = '0;
  logic [4:0]  op_code = '0;
  logic [15:0] result;
  logic        ovf_flag;
  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  alu16_core uut (
    .opnd_a(opnd_a), .opnd_b(opnd_b), .op_code(op_code),
    .result(result), .ovf_flag(ovf_flag)
  );

  // reference model: {ovf, result} from the requirement text
  function automatic logic [16:0] model(logic [4:0] c, logic [15:0] a, logic [15:0] b);
    int sa = $signed(a);
    int sb = $signed(b);
    int ua = int'(a);
    int ub = int'(b);
    int t;
    logic [3:0]  amt = b[3:0];
    logic [15:0] r = '0;
    logic        o = 1'b0;
    case (c)
      5'b00000: begin t = sa + sb; r = t[15:0]; o = (t > 32767) || (t < -32768); end
      5'b00001: begin t = ua + ub; r = t[15:0]; o = t > 65535; end
      5'b00010: begin t = sa - sb; r = t[15:0]; o = (t > 32767) || (t < -32768); end
      5'b00011: begin t = ua - ub; r = t[15:0]; o = ua < ub; end
      5'b00100: begin t = sa + 1;  r = t[15:0]; o = t > 32767; end
      5'b00101: begin t = sa - 1;  r = t[15:0]; o = t < -32768; end
      5'b01000: r = a & b;
      5'b01001: r = a | b;
      5'b01010: r = a ^ b;
      5'b01100: r = ~a;
      5'b10000, 5'b10010: r = a << amt;
      5'b10001: r = a >> amt;
      5'b10011: begin t = sa >>> amt; r = t[15:0]; end
      5'b11000: r = {15'd0, sa <= sb};
      5'b11001: r = {15'd0, sa <  sb};
      5'b11010: r = {15'd0, sa >= sb};
      5'b11011: r = {15'd0, sa >  sb};
      5'b11100: r = {15'd0, sa == sb};
      5'b11101: r = {15'd0, sa != sb};
      default:  begin r = '0; o = 1'b0; end
    endcase
    return {o, r};
  endfunction

  function automatic string req_of(logic [4:0] c);
    case (c[4:3])
      2'b00:   return (c[2:0] > 3'd5) ? "R1/R9" : "R1/R2/R3";
      2'b01:   return (c[2:0] == 3'd3 || c[2:0] > 3'd4) ? "R1/R9" : "R1/R4/R8";
      2'b10:   return c[2] ? "R1/R9" : "R1/R5/R6/R8";
      default: return (c[2:0] > 3'd5) ? "R1/R9" : "R1/R7/R8";
    endcase
  endfunction

  task automatic apply_check(input logic [4:0] c, input logic [15:0] a,
                             input logic [15:0] b, input string tag);
    logic [16:0] exp;
    @(posedge clk);
    op_code = c; opnd_a = a; opnd_b = b;
    @(negedge clk);
    exp = model(c, a, b);
    checks++;
    if ({ovf_flag, result} !== exp) begin
      failures++;
      $display("FAIL %s code=%b a=%h b=%h got ovf=%b res=%h exp ovf=%b res=%h",
               tag, c, a, b, ovf_flag, result, exp[16], exp[15:0]);
    end
  endtask

  logic [15:0] corners [0:13] = '{16'h0000, 16'h0001, 16'h0002, 16'h7FFE,
                                  16'h7FFF, 16'h8000, 16'h8001, 16'hFFFE,
                                  16'hFFFF, 16'h00F0, 16'h5A5A, 16'hA5A5,
                                  16'hFFF0, 16'h800F};

  initial begin
    logic [15:0] lfsr_a = 16'hACE1;
    logic [15:0] lfsr_b = 16'h1D2C;
    // state with all-zero inputs: signed add of zeros gives zero, no flag (R2)
    apply_check(5'b00000, 16'h0000, 16'h0000, "R2 idle");
    // named edge cases
    apply_check(5'b00000, 16'h7FFF, 16'h0001, "R3 signed add overflow");
    apply_check(5'b00001, 16'hFFFF, 16'h0001, "R3 carry out");
    apply_check(5'b00011, 16'h1234, 16'h1234, "R3 no borrow when equal");
    apply_check(5'b00101, 16'h8000, 16'h0000, "R3 decrement overflow");
    apply_check(5'b00100, 16'h7FFF, 16'h0000, "R3 increment overflow");
    apply_check(5'b10011, 16'h8000, 16'hFFFF, "R6 sign fill by 15");
    apply_check(5'b10010, 16'hC003, 16'h0011, "R6 arith left equals logical");
    apply_check(5'b10001, 16'hFFFF, 16'hFFF0, "R5 upper B ignored");
    apply_check(5'b11001, 16'h8000, 16'h0001, "R7 signed less-than");
    apply_check(5'b01100, 16'h00FF, 16'h1234, "R4 invert ignores B");
    apply_check(5'b00111, 16'hFFFF, 16'hFFFF, "R9 undefined arithmetic");
    apply_check(5'b10111, 16'hFFFF, 16'h0003, "R9 undefined shift");
    // R1: every code crossed with edge operands
    for (int c = 0; c < 32; c++)
      for (int i = 0; i < 14; i++)
        for (int j = 0; j < 14; j++)
          apply_check(5'(c), corners[i], corners[j], req_of(5'(c)));
    // pseudo-random operands over every code (R2..R9)
    for (int n = 0; n < 200; n++) begin
      lfsr_a = {lfsr_a[14:0], lfsr_a[15] ^ lfsr_a[13] ^ lfsr_a[12] ^ lfsr_a[10]};
      lfsr_b = {lfsr_b[14:0], lfsr_b[15] ^ lfsr_b[13] ^ lfsr_b[12] ^ lfsr_b[10]};
      for (int c = 0; c < 32; c++)
        apply_check(5'(c), lfsr_a, lfsr_b, req_of(5'(c)));
    end
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired before the sweep ended");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule